// File: doc/BRIEF.md
# Loop-Counter Conditional Branch Unit

This unit carries out one loop-closing branch for a DSP-style pipeline. It takes an instruction word, the program counter of that instruction, the contents of the loop counter register named in the word, the contents of a general register used as an absolute target, and a condition-true bit. The condition bit comes from flag logic outside the unit. The counter register is a 32-bit word. Only its low 24 bits are counted down, as a signed number, and the top 8 bits pass through unchanged. The new counter value is always written back. The branch is taken when the outside condition holds and the counted-down value is not negative.

The target has two forms, chosen by one instruction bit. It is either the value of a named general register, or the instruction's PC plus one plus a signed 16-bit offset. A taken branch occupies four cycles in all. The unit raises a flush request and stays busy for the three cycles after acceptance. A branch that falls through finishes in a single cycle, and its new PC is the old PC plus one. Results appear with a one-cycle `done` strobe.

Instruction layout: bits 31..26 hold the opcode 011011. Bit 25 is the target mode. Bits 24..22 name the counter register. Bits 15..0 hold the offset, and in register mode bits 4..0 name the source register.

Top module: `dbr_exec_unit`

## Requirements
- R1: After reset, `busy`, `flush_req`, `done`, `taken` and `illegal` are all 0.
- R2: On `done`, `aux_wr_data` has bits 31..24 equal to the accepted counter value and bits 23..0 equal to its low 24 bits minus one, modulo 2^24. `aux_wr_idx` equals instruction bits 24..22. This write happens whether or not the branch is taken.
- R3: The branch is taken exactly when `cond_true` is 1 and bit 23 of the counted-down value is 0.
- R4: With bit 25 = 0 (register mode), a taken branch gives `pc_out` = `src_val`. `src_rd_idx` presents instruction bits 4..0 in the same cycle.
- R5: With bit 25 = 1 (relative mode), a taken branch gives `pc_out` = `pc_in` + 1 + the sign-extended value of bits 15..0, modulo 2^32.
- R6: A branch that is not taken raises `done` in the cycle after acceptance with `pc_out` = `pc_in` + 1, `taken` = 0, and neither `busy` nor `flush_req` set.
- R7: A taken branch holds `busy` and `flush_req` high for the three cycles after acceptance. `done` and `taken` rise in the third of these cycles, so the instruction occupies four cycles in total.
- R8: A valid word whose bits 31..26 are not 011011, offered while not busy, raises `illegal` for one cycle in the next cycle. It produces no `done` and no `busy`.
- R9: In register mode, a source index of 28 to 31 is treated as illegal in the same way as R8. Index 27 is accepted.
- R10: `in_valid` is ignored while `busy` is 1. No `illegal` and no extra `done` result from it, and the pending result is not altered.
- R11: `done` lasts one cycle for a taken branch, and `pc_out`, `aux_wr_idx`, `aux_wr_data` and `taken` read 0 when `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered this cycle |
| instr | input | 32 | Instruction word |
| pc_in | input | 32 | PC of the offered instruction |
| aux_val | input | 32 | Counter register contents for `aux_rd_idx` |
| src_val | input | 32 | General register contents for `src_rd_idx` |
| cond_true | input | 1 | Externally evaluated branch condition |
| aux_rd_idx | output | 3 | Counter register read index |
| src_rd_idx | output | 5 | Source register read index |
| busy | output | 1 | Flush in progress, new input ignored |
| flush_req | output | 1 | Pipeline flush request |
| done | output | 1 | Result strobe |
| taken | output | 1 | Branch taken, valid with `done` |
| pc_out | output | 32 | New PC, valid with `done` |
| aux_wr_idx | output | 3 | Counter write-back index |
| aux_wr_data | output | 32 | Counter write-back value |
| illegal | output | 1 | Rejected instruction strobe |

## Verification
The bench builds the unit with its default parameters: a 32-bit word, a 24-bit counter field, a 16-bit offset, 28 source registers and a four-cycle taken path. The 24-bit field lets the tests reach the counter wrap from 0 to all ones, and the crossing from 0x800000 to 0x7FFFFF, without touching the top byte. The 28-register limit puts the accept/reject boundary at index 27 and index 28, inside the 5-bit field. The three-cycle hold is long enough to offer instructions in the middle of a flush and confirm that they are dropped.

// File: rtl/dbr_pkg.sv
package dbr_pkg;
   typedef enum logic {
      TGT_REG = 1'b0,
      TGT_REL = 1'b1
   } tgt_mode_e;
endpackage

// File: rtl/dbr_decode.sv
module dbr_decode
   import dbr_pkg::*;
#(
   parameter int WORD_W    = 32,
   parameter int OPC_W     = 6,
   parameter int AUX_IDX_W = 3,
   parameter int SRC_IDX_W = 5,
   parameter int SRC_REGS  = 28,
   parameter logic [OPC_W-1:0] OPCODE = 6'b011011
) (
   input  logic                 in_valid,
   input  logic                 busy,
   input  logic [WORD_W-1:0]    instr,
   output tgt_mode_e            mode,
   output logic [AUX_IDX_W-1:0] aux_idx,
   output logic [SRC_IDX_W-1:0] src_idx,
   output logic                 acc,
   output logic                 bad
);
   localparam int MODE_POS = WORD_W - OPC_W - 1;
   localparam int AUX_HI   = MODE_POS - 1;
   localparam logic [SRC_IDX_W-1:0] SRC_LIM = SRC_IDX_W'(SRC_REGS - 1);

   if (SRC_REGS > (1 << SRC_IDX_W) || SRC_REGS < 1) begin : g_bad_regs
      $error("SRC_REGS does not fit the source index field");
   end
   if (AUX_HI - AUX_IDX_W + 1 < SRC_IDX_W) begin : g_bad_layout
      $error("instruction fields overlap");
   end

   logic opc_hit, src_ok, offered;
   logic unused_bits;

   assign unused_bits = ^instr;
   assign mode    = tgt_mode_e'(instr[MODE_POS]);
   assign aux_idx = instr[AUX_HI -: AUX_IDX_W];
   assign src_idx = instr[SRC_IDX_W-1:0];
   assign opc_hit = (instr[WORD_W-1 -: OPC_W] == OPCODE);
   assign src_ok  = (mode == TGT_REL) || (src_idx <= SRC_LIM);
   assign offered = in_valid && !busy;
   assign acc     = offered && opc_hit && src_ok;
   assign bad     = offered && !(opc_hit && src_ok);

   // R10
   always_comb begin
      busy_gate_chk: assert (!(busy && (acc || bad)));
   end
endmodule

// File: rtl/dbr_auxdec.sv
module dbr_auxdec #(
   parameter int WORD_W = 32,
   parameter int CNT_W  = 24
) (
   input  logic [WORD_W-1:0] cur,
   output logic [WORD_W-1:0] nxt,
   output logic              nonneg
);
   if (CNT_W < 2 || CNT_W > WORD_W) begin : g_bad_cnt
      $error("CNT_W out of range");
   end

   logic [CNT_W-1:0] low_dec;
   assign low_dec = cur[CNT_W-1:0] - CNT_W'(1);
   assign nonneg  = !low_dec[CNT_W-1];

   if (CNT_W == WORD_W) begin : g_full
      assign nxt = low_dec;
   end else begin : g_part
      assign nxt = {cur[WORD_W-1:CNT_W], low_dec};
   end

   // R2
   always_comb begin
      aux_wrap_chk: assert (nxt[CNT_W-1:0] + CNT_W'(1) == cur[CNT_W-1:0]);
   end
endmodule

// File: rtl/dbr_target.sv
module dbr_target
   import dbr_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int DISP_W = 16
) (
   input  tgt_mode_e         mode,
   input  logic [WORD_W-1:0] pc,
   input  logic [WORD_W-1:0] reg_tgt,
   input  logic [DISP_W-1:0] disp,
   output logic [WORD_W-1:0] seq_pc,
   output logic [WORD_W-1:0] tgt_pc
);
   logic [WORD_W-1:0] disp_x;

   if (DISP_W > WORD_W) begin : g_bad_disp
      $error("DISP_W wider than WORD_W");
   end else if (DISP_W == WORD_W) begin : g_disp_full
      assign disp_x = disp;
   end else begin : g_disp_sext
      assign disp_x = {{(WORD_W-DISP_W){disp[DISP_W-1]}}, disp};
   end

   assign seq_pc = pc + WORD_W'(1);
   assign tgt_pc = (mode == TGT_REL) ? seq_pc + disp_x : reg_tgt;
endmodule

// File: rtl/dbr_exec_unit.sv
module dbr_exec_unit
   import dbr_pkg::*;
#(
   parameter int WORD_W       = 32,
   parameter int CNT_W        = 24,
   parameter int AUX_IDX_W    = 3,
   parameter int SRC_IDX_W    = 5,
   parameter int SRC_REGS     = 28,
   parameter int DISP_W       = 16,
   parameter int OPC_W        = 6,
   parameter logic [OPC_W-1:0] OPCODE = 6'b011011,
   parameter int TAKEN_CYCLES = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [WORD_W-1:0]    instr,
   input  logic [WORD_W-1:0]    pc_in,
   input  logic [WORD_W-1:0]    aux_val,
   input  logic [WORD_W-1:0]    src_val,
   input  logic                 cond_true,
   output logic [AUX_IDX_W-1:0] aux_rd_idx,
   output logic [SRC_IDX_W-1:0] src_rd_idx,
   output logic                 busy,
   output logic                 flush_req,
   output logic                 done,
   output logic                 taken,
   output logic [WORD_W-1:0]    pc_out,
   output logic [AUX_IDX_W-1:0] aux_wr_idx,
   output logic [WORD_W-1:0]    aux_wr_data,
   output logic                 illegal
);
   localparam int HOLD   = TAKEN_CYCLES - 1;
   localparam int HOLD_W = (HOLD < 2) ? 1 : $clog2(HOLD + 1);
   localparam logic [HOLD_W-1:0] HOLD_V = HOLD_W'(HOLD);
   localparam logic [HOLD_W-1:0] LAST_V = HOLD_W'(1);

   if (TAKEN_CYCLES < 2) begin : g_bad_cycles
      $error("TAKEN_CYCLES must be at least 2");
   end

   tgt_mode_e             mode;
   logic                  acc, bad, nonneg, br_take;
   logic [WORD_W-1:0]     aux_nxt, seq_pc, tgt_pc;

   logic [HOLD_W-1:0]     hold_q;
   logic                  nt_done_q, taken_q, illegal_q;
   logic [WORD_W-1:0]     pc_q, aux_q;
   logic [AUX_IDX_W-1:0]  idx_q;

   dbr_decode #(
      .WORD_W(WORD_W), .OPC_W(OPC_W), .AUX_IDX_W(AUX_IDX_W),
      .SRC_IDX_W(SRC_IDX_W), .SRC_REGS(SRC_REGS), .OPCODE(OPCODE)
   ) u_dec (
      .in_valid(in_valid), .busy(busy), .instr(instr), .mode(mode),
      .aux_idx(aux_rd_idx), .src_idx(src_rd_idx), .acc(acc), .bad(bad)
   );

   dbr_auxdec #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_cnt (
      .cur(aux_val), .nxt(aux_nxt), .nonneg(nonneg)
   );

   dbr_target #(.WORD_W(WORD_W), .DISP_W(DISP_W)) u_tgt (
      .mode(mode), .pc(pc_in), .reg_tgt(src_val),
      .disp(instr[DISP_W-1:0]), .seq_pc(seq_pc), .tgt_pc(tgt_pc)
   );

   assign br_take = cond_true && nonneg;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q    <= '0;
         nt_done_q <= 1'b0;
         taken_q   <= 1'b0;
         illegal_q <= 1'b0;
         pc_q      <= '0;
         aux_q     <= '0;
         idx_q     <= '0;
      end else begin
         nt_done_q <= 1'b0;
         illegal_q <= bad;
         if (hold_q != '0) hold_q <= hold_q - LAST_V;
         if (acc) begin
            aux_q   <= aux_nxt;
            idx_q   <= aux_rd_idx;
            taken_q <= br_take;
            pc_q    <= br_take ? tgt_pc : seq_pc;
            if (br_take) hold_q <= HOLD_V;
            else         nt_done_q <= 1'b1;
         end
      end
   end

   assign busy        = (hold_q != '0);
   assign flush_req   = busy;
   assign done        = nt_done_q || (hold_q == LAST_V);
   assign taken       = done && taken_q;
   assign pc_out      = done ? pc_q : '0;
   assign aux_wr_data = done ? aux_q : '0;
   assign aux_wr_idx  = done ? idx_q : '0;
   assign illegal     = illegal_q;

   // R7
   busy_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(acc && br_take));
   // R7
   taken_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && br_take) |=> (busy && (done == (HOLD == 1))));
   // R6
   nt_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !br_take) |=> (done && !busy && !taken));
   // R8
   illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (!done && !busy));
   // R11
   taken_done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && taken) |=> !done);
endmodule

// File: tb/tb_dbr_exec_unit.sv
`timescale 1ns/1ps
module tb_dbr_exec_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] instr = '0, pc_in = '0, aux_val = '0, src_val = '0;
   logic        cond_true = 1'b0;
   logic [2:0]  aux_rd_idx, aux_wr_idx;
   logic [4:0]  src_rd_idx;
   logic        busy, flush_req, done, taken, illegal;
   logic [31:0] pc_out, aux_wr_data;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   dbr_exec_unit dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
      .pc_in(pc_in), .aux_val(aux_val), .src_val(src_val),
      .cond_true(cond_true), .aux_rd_idx(aux_rd_idx), .src_rd_idx(src_rd_idx),
      .busy(busy), .flush_req(flush_req), .done(done), .taken(taken),
      .pc_out(pc_out), .aux_wr_idx(aux_wr_idx), .aux_wr_data(aux_wr_data),
      .illegal(illegal)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input logic m, input logic [2:0] a, input logic [15:0] f);
      return {6'b011011, m, a, 6'b0, f};
   endfunction

   function automatic logic [31:0] exp_aux(input logic [31:0] a);
      logic [23:0] lo;
      lo = a[23:0] - 24'd1;
      return {a[31:24], lo};
   endfunction

   function automatic logic exp_take(input logic [31:0] a, input logic c);
      logic [31:0] n;
      n = exp_aux(a);
      return c && !n[23];
   endfunction

   function automatic logic [31:0] exp_tgt(input logic [31:0] ins, pc, sv);
      if (ins[25]) return pc + 32'd1 + {{16{ins[15]}}, ins[15:0]};
      return sv;
   endfunction

   // offers one legal instruction at a negedge and follows it to completion
   task automatic run_op(input logic [31:0] ins, pc, av, sv, input logic c);
      logic        tk;
      logic [31:0] epc;
      tk  = exp_take(av, c);
      epc = tk ? exp_tgt(ins, pc, sv) : pc + 32'd1;
      instr = ins; pc_in = pc; aux_val = av; src_val = sv; cond_true = c;
      in_valid = 1'b1;
      #1;
      chk("R4 src_rd_idx", {27'd0, src_rd_idx}, {27'd0, ins[4:0]});
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      if (tk) begin
         for (int k = 1; k <= 3; k++) begin
            chk("R7 busy", {31'd0, busy}, 32'd1);
            chk("R7 flush", {31'd0, flush_req}, 32'd1);
            chk("R7 done", {31'd0, done}, {31'd0, k == 3});
            if (k == 3) begin
               chk(ins[25] ? "R5 pc" : "R4 pc", pc_out, epc);
               chk("R3 taken", {31'd0, taken}, 32'd1);
               chk("R2 aux data", aux_wr_data, exp_aux(av));
               chk("R2 aux idx", {29'd0, aux_wr_idx}, {29'd0, ins[24:22]});
            end else begin
               chk("R11 pc idle", pc_out, 32'd0);
               @(negedge clk);
            end
         end
         @(negedge clk);
         chk("R11 single done", {31'd0, done}, 32'd0);
         chk("R7 busy end", {31'd0, busy}, 32'd0);
      end else begin
         chk("R6 done", {31'd0, done}, 32'd1);
         chk("R6 busy", {31'd0, busy | flush_req}, 32'd0);
         chk("R3 not taken", {31'd0, taken}, 32'd0);
         chk("R6 pc", pc_out, epc);
         chk("R2 aux data", aux_wr_data, exp_aux(av));
         chk("R2 aux idx", {29'd0, aux_wr_idx}, {29'd0, ins[24:22]});
         @(negedge clk);
         chk("R11 done clear", {31'd0, done}, 32'd0);
         chk("R11 data clear", aux_wr_data, 32'd0);
      end
   endtask

   task automatic run_bad(input logic [31:0] ins, input string req);
      instr = ins; in_valid = 1'b1; cond_true = 1'b1; aux_val = 32'd10;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      chk(req, {31'd0, illegal}, 32'd1);
      chk(req, {30'd0, done, busy}, 32'd0);
      @(negedge clk);
      chk(req, {29'd0, illegal, done, busy}, 32'd0);
   endtask

   initial begin
      #(20 * 200000);
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] seed_dummy;
      seed_dummy = $urandom(32'd7731);
      repeat (3) @(negedge clk);
      // R1
      chk("R1 reset", {27'd0, busy, flush_req, done, taken, illegal}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after reset", {27'd0, busy, flush_req, done, taken, illegal}, 32'd0);

      // R3 wrap 0 -> all ones: negative, upper byte kept (R2)
      run_op(mk(1'b0, 3'd2, 16'd3), 32'h40, 32'hA500_0000, 32'h999, 1'b1);
      // R3 1 -> 0: taken, register mode (R4)
      run_op(mk(1'b0, 3'd5, 16'd5), 32'h80, 32'h0000_0001, 32'h1234_5678, 1'b1);
      // R3 condition false
      run_op(mk(1'b0, 3'd1, 16'd1), 32'h90, 32'h0000_0005, 32'h1, 1'b0);
      // R5 negative displacement
      run_op(mk(1'b1, 3'd7, 16'hFFF0), 32'h100, 32'h0000_0010, 32'h0, 1'b1);
      // R5 wrap across address top
      run_op(mk(1'b1, 3'd0, 16'h0010), 32'hFFFF_FFF8, 32'hFF00_0003, 32'h0, 1'b1);
      // R3 0x800000 -> 0x7FFFFF positive
      run_op(mk(1'b1, 3'd3, 16'h0004), 32'h200, 32'h3C80_0000, 32'h0, 1'b1);
      // R9 index 27 accepted
      run_op(mk(1'b0, 3'd4, 16'd27), 32'h300, 32'h0000_0100, 32'hCAFE_0000, 1'b1);

      // R8 wrong opcode
      run_bad({6'b011010, 26'h0}, "R8 illegal opcode");
      // R9 index 28 rejected in register mode
      run_bad(mk(1'b0, 3'd1, 16'd28), "R9 src index 28");

      // R10 input during busy is ignored
      instr = mk(1'b1, 3'd6, 16'h0020); pc_in = 32'h500;
      aux_val = 32'h0000_0009; cond_true = 1'b1; in_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      instr = {6'b000001, 26'h0}; pc_in = 32'h777;
      for (int k = 1; k <= 3; k++) begin
         chk("R10 no illegal", {31'd0, illegal}, 32'd0);
         if (k == 3) begin
            chk("R10 result kept", pc_out, 32'h521);
            in_valid = 1'b0;
         end else begin
            chk("R10 no early done", {31'd0, done}, 32'd0);
            @(negedge clk);
         end
      end
      @(negedge clk);
      chk("R10 no extra done", {30'd0, done, illegal}, 32'd0);

      // random mix
      for (int i = 0; i < 300; i++) begin
         logic [31:0] ins, av;
         logic        m;
         logic [15:0] f;
         m  = 1'($urandom);
         f  = m ? 16'($urandom) : 16'($urandom_range(0, 27));
         av = $urandom;
         case ($urandom_range(0, 3))
            0: av[23:0] = 24'd0;
            1: av[23:0] = 24'd1;
            2: av[23:0] = 24'h800000;
            default: ;
         endcase
         ins = mk(m, 3'($urandom), f);
         run_op(ins, $urandom, av, $urandom, 1'($urandom));
      end

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule